// File: doc/BRIEF.md
# Software-Managed Associative Translation Buffer

This block is a fully associative address translation cache whose contents are placed by software. Each slot holds a virtual page-pair number, a per-slot page mask, an address-space tag, and two frame descriptors, one for the even page and one for the odd page of the pair. Software fills a slot by naming its index and supplying the high word (page number and tag), the mask word and the two descriptor words. It can read any slot back, probe for the slot that matches a given high word, and clear the whole table in one cycle.

The translation side takes a 32-bit virtual address, a tag and an access kind (read or write). One clock later it returns whether a slot matched, which slot, the descriptor of the selected page, and an uncached flag derived from the address alone. Per-kind hit, miss and access counters run alongside, together with a counter of accesses that hit a slot whose selected page is not usable. A round-robin slot pointer is offered to the software refill routine for choosing a victim.

Top module: `soft_tlb`

## Requirements
- R1: A lookup presented with `lk_en` high produces its result one clock later with `lk_done` high; with no request in the previous cycle, `lk_done`, `lk_hit`, `lk_idx`, `lk_frame` and `lk_uncached` are all zero. Page number bits (address bits 31..11) take part in the compare only where the slot's mask bit is zero; bits where the mask is one are ignored.
- R2: A slot matches only if it is global or its stored tag equals `lk_asid`. A slot is global when bit 0 of both of its descriptors is one.
- R3: A slot whose two descriptors both have bit 1 (valid) clear never matches a lookup or a probe.
- R4: When several slots match, `lk_idx` reports the lowest-numbered one.
- R5: On a hit, `lk_frame` is the odd-page descriptor if address bit 10 is one, otherwise the even-page descriptor. Descriptor layout: frame number from bit 6 upward, cache attribute in bits 5..3, dirty at bit 2, valid at bit 1, global at bit 0.
- R6: A probe on `pr_hi` (page number in bits 31..11, tag in the low `ASID_W` bits) returns, one clock later, the lowest matching slot index with the top bit zero, or all ones when nothing matches; with no probe the result is zero.
- R7: `rd_hi`, `rd_mask`, `rd_lo0`, `rd_lo1` show slot `rd_idx` one clock after it is presented; `rd_hi` carries the page number in bits 31..11 and the tag in the low `ASID_W` bits with the bits between read as zero, and `rd_mask` carries the mask in bits 31..11 with the low bits zero.
- R8: A write with `wr_idx` of `ENTRIES` or more changes no slot and raises `wr_warn` for exactly the following cycle.
- R9: `flush` clears every slot to zero and returns the slot pointer to 0; a write in the same cycle is dropped.
- R10: `nx_ptr` advances by one per cycle with `nx_step` high, wrapping from `ENTRIES-1` to 0.
- R11: `lk_uncached` is one when address bits 31 and 29 are both set.
- R12: Hit, miss and access counts are kept apart for read and write lookups; `cnt_hit`, `cnt_miss` and `cnt_acc` are the sums of the read and write counts; every counter is updated in the same clock as the lookup result.
- R13: `cnt_viol` counts lookups that hit a slot whose selected descriptor has valid clear, or, for a write, has dirty clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_en | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_idx | output | IDX_W | Matching slot index |
| lk_frame | output | 32 | Selected page descriptor |
| lk_uncached | output | 1 | Address is in the uncached window |
| pr_en | input | 1 | Probe request |
| pr_hi | input | 32 | Probe high word |
| pr_done | output | 1 | Probe result valid |
| pr_result | output | IDX_W+1 | Probe index or all ones |
| rd_idx | input | IDX_W | Slot to read back |
| rd_hi | output | 32 | Read-back high word |
| rd_mask | output | 32 | Read-back mask word |
| rd_lo0 | output | 32 | Read-back even descriptor |
| rd_lo1 | output | 32 | Read-back odd descriptor |
| wr_en | input | 1 | Slot write request |
| wr_idx | input | IDX_W+1 | Slot to write |
| wr_hi | input | 32 | High word to write |
| wr_mask | input | 32 | Mask word to write |
| wr_lo0 | input | 32 | Even descriptor to write |
| wr_lo1 | input | 32 | Odd descriptor to write |
| wr_warn | output | 1 | Previous write was out of range |
| flush | input | 1 | Clear the whole table |
| nx_step | input | 1 | Advance the slot pointer |
| nx_ptr | output | IDX_W | Slot pointer |
| cnt_rd_hit | output | CNT_W | Read hits |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_rd_acc | output | CNT_W | Read accesses |
| cnt_wr_hit | output | CNT_W | Write hits |
| cnt_wr_miss | output | CNT_W | Write misses |
| cnt_wr_acc | output | CNT_W | Write accesses |
| cnt_hit | output | CNT_W | Total hits |
| cnt_miss | output | CNT_W | Total misses |
| cnt_acc | output | CNT_W | Total accesses |
| cnt_viol | output | CNT_W | Access violations |

## Verification
A corrupted slot surfaces at the ports on the first lookup, probe or read-back that touches it, one clock after the request: a wrong page number, mask or tag turns a hit into a miss or moves `lk_idx`, while a wrong descriptor shows in `lk_frame` and in `cnt_viol` in that same cycle. A slot pointer or counter that drifts differs from the reference on the very next clock, since both are visible continuously. A flush or out-of-range write that leaks state shows up as an unexpected hit on the next lookup of the affected page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WORD_W   = 32;
  localparam int HI_SHIFT = 11;
  localparam int VPN_W    = WORD_W - HI_SHIFT;
  localparam int SEL_BIT  = HI_SHIFT - 1;
  localparam int DSC_G    = 0;
  localparam int DSC_V    = 1;
  localparam int DSC_D    = 2;
  localparam logic [WORD_W-1:0] UNCACHED_PAT = 32'hA000_0000;

  // Address window that bypasses the caches.
  function automatic logic is_uncached(input logic [WORD_W-1:0] va);
    return (va & UNCACHED_PAT) == UNCACHED_PAT;
  endfunction

  // A slot is live when either page of the pair is valid.
  function automatic logic pair_live(input logic [WORD_W-1:0] d0, input logic [WORD_W-1:0] d1);
    return d0[DSC_V] | d1[DSC_V];
  endfunction

  // Global only when both descriptors say so.
  function automatic logic pair_global(input logic [WORD_W-1:0] d0, input logic [WORD_W-1:0] d1);
    return d0[DSC_G] & d1[DSC_G];
  endfunction

  function automatic logic is_violation(input logic hit, input logic wr,
                                        input logic [WORD_W-1:0] sel);
    return hit && (!sel[DSC_V] || (wr && !sel[DSC_D]));
  endfunction
endpackage

// File: rtl/tlb_matcher.sv
module tlb_matcher #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 21,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_mask,
  input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  input  logic [ENTRIES-1:0]             ent_live,
  input  logic [ENTRIES-1:0]             ent_glob,
  input  logic [VPN_W-1:0]               req_vpn,
  input  logic [ASID_W-1:0]              req_asid,
  output logic                           found,
  output logic [IDX_W-1:0]               first_idx
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = ent_live[i]
                     && (((req_vpn ^ ent_vpn[i]) & ~ent_mask[i]) == '0)
                     && (ent_glob[i] || (req_asid == ent_asid[i]));
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    found     = |hit_vec;
    first_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) first_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_counters.sv
module tlb_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             wr,
  input  logic             hit,
  input  logic             viol,
  output logic [CNT_W-1:0] rd_hit,
  output logic [CNT_W-1:0] rd_miss,
  output logic [CNT_W-1:0] rd_acc,
  output logic [CNT_W-1:0] wr_hit,
  output logic [CNT_W-1:0] wr_miss,
  output logic [CNT_W-1:0] wr_acc,
  output logic [CNT_W-1:0] viol_cnt,
  output logic [CNT_W-1:0] tot_hit,
  output logic [CNT_W-1:0] tot_miss,
  output logic [CNT_W-1:0] tot_acc
);
  localparam int N_CNT = 7;
  localparam int K_RH = 0, K_RM = 1, K_RA = 2, K_WH = 3, K_WM = 4, K_WA = 5, K_VI = 6;

  logic [N_CNT-1:0] bump;
  logic [CNT_W-1:0] cnt [N_CNT];

  always_comb begin
    bump       = '0;
    bump[K_RH] = acc && !wr && hit;
    bump[K_RM] = acc && !wr && !hit;
    bump[K_RA] = acc && !wr;
    bump[K_WH] = acc && wr && hit;
    bump[K_WM] = acc && wr && !hit;
    bump[K_WA] = acc && wr;
    bump[K_VI] = acc && viol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_CNT; k++) cnt[k] <= '0;
    end else begin
      for (int k = 0; k < N_CNT; k++) begin
        if (bump[k]) cnt[k] <= cnt[k] + 1'b1;
      end
    end
  end

  assign rd_hit   = cnt[K_RH];
  assign rd_miss  = cnt[K_RM];
  assign rd_acc   = cnt[K_RA];
  assign wr_hit   = cnt[K_WH];
  assign wr_miss  = cnt[K_WM];
  assign wr_acc   = cnt[K_WA];
  assign viol_cnt = cnt[K_VI];
  assign tot_hit  = cnt[K_RH] + cnt[K_WH];
  assign tot_miss = cnt[K_RM] + cnt[K_WM];
  assign tot_acc  = cnt[K_RA] + cnt[K_WA];
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ASID_W  = 8,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic              lk_write,
  input  logic [31:0]       lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [31:0]       lk_frame,
  output logic              lk_uncached,
  input  logic              pr_en,
  input  logic [31:0]       pr_hi,
  output logic              pr_done,
  output logic [IDX_W:0]    pr_result,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_hi,
  output logic [31:0]       rd_mask,
  output logic [31:0]       rd_lo0,
  output logic [31:0]       rd_lo1,
  input  logic              wr_en,
  input  logic [IDX_W:0]    wr_idx,
  input  logic [31:0]       wr_hi,
  input  logic [31:0]       wr_mask,
  input  logic [31:0]       wr_lo0,
  input  logic [31:0]       wr_lo1,
  output logic              wr_warn,
  input  logic              flush,
  input  logic              nx_step,
  output logic [IDX_W-1:0]  nx_ptr,
  output logic [CNT_W-1:0]  cnt_rd_hit,
  output logic [CNT_W-1:0]  cnt_rd_miss,
  output logic [CNT_W-1:0]  cnt_rd_acc,
  output logic [CNT_W-1:0]  cnt_wr_hit,
  output logic [CNT_W-1:0]  cnt_wr_miss,
  output logic [CNT_W-1:0]  cnt_wr_acc,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_miss,
  output logic [CNT_W-1:0]  cnt_acc,
  output logic [CNT_W-1:0]  cnt_viol
);
  localparam logic [IDX_W:0]   ENTRIES_X = (IDX_W + 1)'(ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(ENTRIES - 1);

  // Slot storage
  logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn, e_mask;
  logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
  logic [ENTRIES-1:0][WORD_W-1:0] e_lo0, e_lo1;
  logic [ENTRIES-1:0]             e_live, e_glob;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_attr
    assign e_live[i] = pair_live(e_lo0[i], e_lo1[i]);
    assign e_glob[i] = pair_global(e_lo0[i], e_lo1[i]);
  end

  // Named internal events
  logic              lk_found, pr_found;
  logic [IDX_W-1:0]  lk_first, pr_first;
  logic [WORD_W-1:0] lk_sel;
  logic              ev_viol;
  logic              wr_in_range, wr_accept, wr_reject;
  logic              ptr_wrap;

  tlb_matcher #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .ent_vpn  (e_vpn),
    .ent_mask (e_mask),
    .ent_asid (e_asid),
    .ent_live (e_live),
    .ent_glob (e_glob),
    .req_vpn  (lk_va[WORD_W-1:HI_SHIFT]),
    .req_asid (lk_asid),
    .found    (lk_found),
    .first_idx(lk_first)
  );

  tlb_matcher #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_pr_match (
    .ent_vpn  (e_vpn),
    .ent_mask (e_mask),
    .ent_asid (e_asid),
    .ent_live (e_live),
    .ent_glob (e_glob),
    .req_vpn  (pr_hi[WORD_W-1:HI_SHIFT]),
    .req_asid (pr_hi[ASID_W-1:0]),
    .found    (pr_found),
    .first_idx(pr_first)
  );

  assign lk_sel      = lk_va[SEL_BIT] ? e_lo1[lk_first] : e_lo0[lk_first];
  assign ev_viol     = is_violation(lk_found, lk_write, lk_sel);
  assign wr_in_range = wr_idx < ENTRIES_X;
  assign wr_accept   = wr_en && wr_in_range && !flush;
  assign wr_reject   = wr_en && !wr_in_range;
  assign ptr_wrap    = nx_step && (nx_ptr == LAST_IDX);

  logic unused_bits;
  assign unused_bits = ^{lk_va[SEL_BIT-1:0], pr_hi[HI_SHIFT-1:ASID_W],
                         wr_hi[HI_SHIFT-1:ASID_W], wr_mask[HI_SHIFT-1:0]};

  // Table update: flush wins over a write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vpn <= '0; e_mask <= '0; e_asid <= '0; e_lo0 <= '0; e_lo1 <= '0;
    end else if (flush) begin
      e_vpn <= '0; e_mask <= '0; e_asid <= '0; e_lo0 <= '0; e_lo1 <= '0;
    end else if (wr_accept) begin
      e_vpn [wr_idx[IDX_W-1:0]] <= wr_hi[WORD_W-1:HI_SHIFT];
      e_mask[wr_idx[IDX_W-1:0]] <= wr_mask[WORD_W-1:HI_SHIFT];
      e_asid[wr_idx[IDX_W-1:0]] <= wr_hi[ASID_W-1:0];
      e_lo0 [wr_idx[IDX_W-1:0]] <= wr_lo0;
      e_lo1 [wr_idx[IDX_W-1:0]] <= wr_lo1;
    end
  end

  // Registered results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_done <= 1'b0; lk_hit <= 1'b0; lk_idx <= '0; lk_frame <= '0; lk_uncached <= 1'b0;
      pr_done <= 1'b0; pr_result <= '0;
      rd_hi <= '0; rd_mask <= '0; rd_lo0 <= '0; rd_lo1 <= '0;
      wr_warn <= 1'b0;
      nx_ptr <= '0;
    end else begin
      lk_done     <= lk_en;
      lk_hit      <= lk_en && lk_found;
      lk_idx      <= (lk_en && lk_found) ? lk_first : '0;
      lk_frame    <= (lk_en && lk_found) ? lk_sel : '0;
      lk_uncached <= lk_en && is_uncached(lk_va);
      pr_done     <= pr_en;
      pr_result   <= !pr_en ? '0 : (pr_found ? {1'b0, pr_first} : '1);
      rd_hi       <= {e_vpn[rd_idx], HI_SHIFT'(e_asid[rd_idx])};
      rd_mask     <= {e_mask[rd_idx], {HI_SHIFT{1'b0}}};
      rd_lo0      <= e_lo0[rd_idx];
      rd_lo1      <= e_lo1[rd_idx];
      wr_warn     <= wr_reject;
      if (flush)         nx_ptr <= '0;
      else if (ptr_wrap) nx_ptr <= '0;
      else if (nx_step)  nx_ptr <= nx_ptr + 1'b1;
    end
  end

  tlb_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (lk_en),
    .wr      (lk_write),
    .hit     (lk_found),
    .viol    (ev_viol),
    .rd_hit  (cnt_rd_hit),
    .rd_miss (cnt_rd_miss),
    .rd_acc  (cnt_rd_acc),
    .wr_hit  (cnt_wr_hit),
    .wr_miss (cnt_wr_miss),
    .wr_acc  (cnt_wr_acc),
    .viol_cnt(cnt_viol),
    .tot_hit (cnt_hit),
    .tot_miss(cnt_miss),
    .tot_acc (cnt_acc)
  );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_en,
  input logic             lk_done,
  input logic             lk_hit,
  input logic             lk_uncached,
  input logic             pr_done,
  input logic [IDX_W:0]   pr_result,
  input logic             wr_en,
  input logic [IDX_W:0]   wr_idx,
  input logic             wr_warn,
  input logic             flush,
  input logic [IDX_W-1:0] nx_ptr,
  input logic [CNT_W-1:0] cnt_acc
);
  localparam logic [IDX_W:0] ENTRIES_X = (IDX_W + 1)'(ENTRIES);

  assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> lk_done);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_done |-> (!lk_hit && !lk_uncached));

  assert_probe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_done |-> (pr_result == '0));

  assert_oob_warn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= ENTRIES_X)) |=> wr_warn);

  assert_warn_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_warn |-> $past(wr_en));

  assert_flush_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (nx_ptr == '0));

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush ##1 lk_en) |=> !lk_hit);

  assert_ptr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, nx_ptr} < ENTRIES_X);

  assert_acc_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> (cnt_acc == CNT_W'($past(cnt_acc) + 1'b1)));

  assert_acc_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> $stable(cnt_acc));
endmodule

bind soft_tlb tlb_checker #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_en      (lk_en),
  .lk_done    (lk_done),
  .lk_hit     (lk_hit),
  .lk_uncached(lk_uncached),
  .pr_done    (pr_done),
  .pr_result  (pr_result),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_warn    (wr_warn),
  .flush      (flush),
  .nx_ptr     (nx_ptr),
  .cnt_acc    (cnt_acc)
);

// File: tb/sim_soft_tlb.sv
`timescale 1ns/1ps
module sim_soft_tlb;
  localparam int ENTRIES = 8;
  localparam int ASID_W  = 8;
  localparam int CNT_W   = 16;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam bit [31:0] AMASK  = (32'd1 << ASID_W) - 1;
  localparam bit [31:0] VPNFLD = 32'hFFFF_F800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic lk_en = 0, lk_write = 0, pr_en = 0, wr_en = 0, flush = 0, nx_step = 0;
  logic [31:0] lk_va = '0, pr_hi = '0, wr_hi = '0, wr_mask = '0, wr_lo0 = '0, wr_lo1 = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [IDX_W:0] wr_idx = '0;
  logic lk_done, lk_hit, lk_uncached, pr_done, wr_warn;
  logic [IDX_W-1:0] lk_idx, nx_ptr;
  logic [31:0] lk_frame, rd_hi, rd_mask, rd_lo0, rd_lo1;
  logic [IDX_W:0] pr_result;
  logic [CNT_W-1:0] cnt_rd_hit, cnt_rd_miss, cnt_rd_acc, cnt_wr_hit, cnt_wr_miss,
                    cnt_wr_acc, cnt_hit, cnt_miss, cnt_acc, cnt_viol;

  soft_tlb #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_en(lk_en), .lk_write(lk_write), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_frame(lk_frame),
    .lk_uncached(lk_uncached),
    .pr_en(pr_en), .pr_hi(pr_hi), .pr_done(pr_done), .pr_result(pr_result),
    .rd_idx(rd_idx), .rd_hi(rd_hi), .rd_mask(rd_mask), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_mask(wr_mask),
    .wr_lo0(wr_lo0), .wr_lo1(wr_lo1), .wr_warn(wr_warn),
    .flush(flush), .nx_step(nx_step), .nx_ptr(nx_ptr),
    .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss), .cnt_rd_acc(cnt_rd_acc),
    .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss), .cnt_wr_acc(cnt_wr_acc),
    .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_acc(cnt_acc), .cnt_viol(cnt_viol)
  );

  int n_checks = 0;
  int n_errors = 0;
  int n_looks  = 0;
  bit armed    = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit [31:0] m_hi [ENTRIES];
  bit [31:0] m_mask[ENTRIES];
  bit [31:0] m_lo0[ENTRIES];
  bit [31:0] m_lo1[ENTRIES];
  int m_ptr;
  int m_rh, m_rm, m_wh, m_wm, m_vi;
  bit        x_done, x_hit, x_unc, x_pdone, x_warn;
  int        x_idx;
  bit [31:0] x_frame, x_rhi, x_rmask, x_rlo0, x_rlo1;
  bit [IDX_W:0] x_pres;

  function automatic int m_find(input bit [31:0] key, input bit [31:0] tag);
    for (int i = 0; i < ENTRIES; i++) begin
      bit live = m_lo0[i][1] || m_lo1[i][1];
      bit glob = m_lo0[i][0] && m_lo1[i][0];
      bit [31:0] care = ~m_mask[i] & VPNFLD;
      if (live && (((key ^ m_hi[i]) & care) == 0) && (glob || ((m_hi[i] & AMASK) == tag)))
        return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        m_hi[i] = 0; m_mask[i] = 0; m_lo0[i] = 0; m_lo1[i] = 0;
      end
      m_ptr = 0; m_rh = 0; m_rm = 0; m_wh = 0; m_wm = 0; m_vi = 0;
      x_done = 0; x_hit = 0; x_unc = 0; x_pdone = 0; x_warn = 0; x_idx = 0;
      x_frame = 0; x_rhi = 0; x_rmask = 0; x_rlo0 = 0; x_rlo1 = 0; x_pres = '0;
    end else begin
      int f, p;
      bit [31:0] sel;
      f = m_find(lk_va, 32'(lk_asid));
      x_done = lk_en;
      x_hit  = lk_en && (f >= 0);
      x_idx  = x_hit ? f : 0;
      sel    = (f >= 0) ? (lk_va[10] ? m_lo1[f] : m_lo0[f]) : 32'd0;
      x_frame = x_hit ? sel : 32'd0;
      x_unc  = lk_en && lk_va[31] && lk_va[29];
      if (lk_en) begin
        if (lk_write) begin if (f >= 0) m_wh++; else m_wm++; end
        else          begin if (f >= 0) m_rh++; else m_rm++; end
        if ((f >= 0) && (!sel[1] || (lk_write && !sel[2]))) m_vi++;
      end
      p = m_find(pr_hi & VPNFLD, pr_hi & AMASK);
      x_pdone = pr_en;
      x_pres  = !pr_en ? '0 : ((p < 0) ? '1 : (IDX_W + 1)'(p));
      x_rhi   = m_hi[rd_idx] & (VPNFLD | AMASK);
      x_rmask = m_mask[rd_idx] & VPNFLD;
      x_rlo0  = m_lo0[rd_idx];
      x_rlo1  = m_lo1[rd_idx];
      x_warn  = wr_en && (int'(wr_idx) >= ENTRIES);
      if (flush) begin
        for (int i = 0; i < ENTRIES; i++) begin
          m_hi[i] = 0; m_mask[i] = 0; m_lo0[i] = 0; m_lo1[i] = 0;
        end
        m_ptr = 0;
      end else begin
        if (wr_en && (int'(wr_idx) < ENTRIES)) begin
          m_hi[wr_idx] = wr_hi; m_mask[wr_idx] = wr_mask;
          m_lo0[wr_idx] = wr_lo0; m_lo1[wr_idx] = wr_lo1;
        end
        if (nx_step) m_ptr = (m_ptr + 1) % ENTRIES;
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (armed && !finished) begin
      check("R1 lookup done", lk_done, x_done);
      check("R1 lookup hit", lk_hit, x_hit);
      check("R4 lookup index", lk_idx, x_idx);
      check("R5 selected frame", lk_frame, x_frame);
      check("R11 uncached flag", lk_uncached, x_unc);
      check("R6 probe done", pr_done, x_pdone);
      check("R6 probe result", pr_result, x_pres);
      check("R7 read hi", rd_hi, x_rhi);
      check("R7 read mask", rd_mask, x_rmask);
      check("R7 read lo0", rd_lo0, x_rlo0);
      check("R7 read lo1", rd_lo1, x_rlo1);
      check("R8 warn flag", wr_warn, x_warn);
      check("R10 slot pointer", nx_ptr, m_ptr);
      check("R12 read hits", cnt_rd_hit, CNT_W'(m_rh));
      check("R12 read misses", cnt_rd_miss, CNT_W'(m_rm));
      check("R12 read accesses", cnt_rd_acc, CNT_W'(m_rh + m_rm));
      check("R12 write hits", cnt_wr_hit, CNT_W'(m_wh));
      check("R12 write misses", cnt_wr_miss, CNT_W'(m_wm));
      check("R12 write accesses", cnt_wr_acc, CNT_W'(m_wh + m_wm));
      check("R12 total hits", cnt_hit, CNT_W'(m_rh + m_wh));
      check("R12 total misses", cnt_miss, CNT_W'(m_rm + m_wm));
      check("R12 total accesses", cnt_acc, CNT_W'(m_rh + m_rm + m_wh + m_wm));
      check("R13 violations", cnt_viol, CNT_W'(m_vi));
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_write(input int idx, input bit [31:0] hi, input bit [31:0] mk,
                          input bit [31:0] d0, input bit [31:0] d1);
    @(negedge clk);
    wr_en = 1; wr_idx = (IDX_W + 1)'(idx); wr_hi = hi; wr_mask = mk; wr_lo0 = d0; wr_lo1 = d1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_look(input bit [31:0] va, input int tag, input bit wr);
    @(negedge clk);
    lk_en = 1; lk_va = va; lk_asid = ASID_W'(tag); lk_write = wr;
    n_looks++;
    @(negedge clk);
    lk_en = 0; lk_write = 0;
  endtask

  task automatic do_probe(input bit [31:0] hi);
    @(negedge clk);
    pr_en = 1; pr_hi = hi;
    @(negedge clk);
    pr_en = 0;
  endtask

  task automatic do_read(input int idx);
    @(negedge clk);
    rd_idx = IDX_W'(idx);
    @(negedge clk);
  endtask

  function automatic bit [31:0] rnd_va();
    return {3'($urandom_range(0, 7)), 15'd0, 3'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 10'd0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int viol0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // reset state
    check("R9 reset pointer", nx_ptr, 0);
    check("R12 reset accesses", cnt_acc, 0);
    check("R1 reset done", lk_done, 0);
    armed = 1;

    // slot 0: private tag 5, even page dirty+valid, odd page valid only
    do_write(0, 32'h0008_0005, 32'h0, 32'h0000_045E, 32'h0000_0482);
    do_look(32'h0008_0000, 5, 0);
    check("R2 tag match hits", lk_hit, 1);
    check("R5 even frame", lk_frame, 32'h045E);
    do_look(32'h0008_0000, 6, 0);
    check("R2 tag mismatch misses", lk_hit, 0);
    do_look(32'h0008_0400, 5, 0);
    check("R5 odd frame", lk_frame, 32'h0482);
    viol0 = int'(cnt_viol);
    do_look(32'h0008_0400, 5, 1);
    check("R13 write to clean page", cnt_viol, CNT_W'(viol0 + 1));

    // slot 1: global, two low page bits masked
    do_write(1, 32'h0010_0009, 32'h0000_1800, 32'h0000_0843, 32'h0000_0881);
    do_look(32'h0010_1800, 2, 0);
    check("R1 masked bits ignored", lk_hit, 1);
    check("R2 global slot any tag", lk_idx, 1);
    do_look(32'h0010_2000, 2, 0);
    check("R1 unmasked bit differs", lk_hit, 0);
    viol0 = int'(cnt_viol);
    do_look(32'h0010_0400, 2, 0);
    check("R13 invalid odd page", cnt_viol, CNT_W'(viol0 + 1));

    // duplicates in slots 5 and 3
    do_write(5, 32'h0018_0000, 32'h0, 32'h0000_1543, 32'h1);
    do_write(3, 32'h0018_0000, 32'h0, 32'h0000_0CC3, 32'h1);
    do_look(32'h0018_0000, 7, 0);
    check("R4 lowest slot wins", lk_idx, 3);
    check("R4 lowest slot frame", lk_frame, 32'h0CC3);
    do_probe(32'h0018_0007);
    check("R6 probe finds lowest", pr_result, 3);

    // slot 4: global but neither page valid
    do_write(4, 32'h0020_0000, 32'h0, 32'h1, 32'h1);
    do_look(32'h0020_0000, 0, 0);
    check("R3 dead slot misses", lk_hit, 0);
    do_probe(32'h0020_0000);
    check("R6 probe not found", pr_result, {(IDX_W + 1){1'b1}});

    // out-of-range write
    do_write(ENTRIES, 32'h0030_0000, 32'h0, 32'h3, 32'h1);
    check("R8 warn raised", wr_warn, 1);
    do_look(32'h0030_0000, 0, 0);
    check("R8 table unchanged", lk_hit, 0);
    check("R8 warn one cycle", wr_warn, 0);

    // read-back with junk bits in the high word
    do_write(2, 32'h0008_0733, 32'h0000_07FF, 32'h0, 32'h0);
    do_read(2);
    check("R7 read hi drops gap bits", rd_hi, 32'h0008_0033);
    check("R7 read mask drops low bits", rd_mask, 32'h0);
    do_read(1);
    check("R7 read hi slot1", rd_hi, 32'h0010_0009);
    check("R7 read mask slot1", rd_mask, 32'h0000_1800);

    // uncached window
    do_look(32'hE000_1000, 0, 0);
    check("R11 uncached window", lk_uncached, 1);
    do_look(32'h8000_0000, 0, 0);
    check("R11 cached address", lk_uncached, 0);

    // slot pointer wrap
    @(negedge clk); nx_step = 1;
    repeat (ENTRIES - 1) @(negedge clk);
    check("R10 pointer at last", nx_ptr, ENTRIES - 1);
    @(negedge clk); nx_step = 0;
    check("R10 pointer wraps", nx_ptr, 0);

    check("R12 accesses counted", cnt_acc, CNT_W'(n_looks));

    // flush
    @(negedge clk); nx_step = 1;
    @(negedge clk); nx_step = 0; flush = 1;
    @(negedge clk); flush = 0;
    check("R9 flush pointer", nx_ptr, 0);
    do_look(32'h0008_0000, 5, 0);
    check("R9 flush empties", lk_hit, 0);
    do_read(0);
    check("R9 flush clears slot", rd_lo0, 32'h0);

    // random traffic against the model
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      lk_en    = 1'($urandom_range(0, 1));
      lk_write = 1'($urandom_range(0, 1));
      lk_va    = rnd_va();
      lk_asid  = ASID_W'($urandom_range(0, 3));
      pr_en    = 1'($urandom_range(0, 1));
      pr_hi    = rnd_va() | 32'($urandom_range(0, 3));
      rd_idx   = IDX_W'($urandom_range(0, ENTRIES - 1));
      wr_en    = ($urandom_range(0, 2) == 0);
      wr_idx   = (IDX_W + 1)'($urandom_range(0, ENTRIES + 1));
      wr_hi    = (rnd_va() & VPNFLD) | 32'($urandom_range(0, 3));
      case ($urandom_range(0, 2))
        0:       wr_mask = 32'h0;
        1:       wr_mask = 32'h0000_1800;
        default: wr_mask = 32'hE000_0000;
      endcase
      wr_lo0   = $urandom & 32'h0000_3FFF;
      wr_lo1   = $urandom & 32'h0000_3FFF;
      flush    = ($urandom_range(0, 59) == 0);
      nx_step  = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    lk_en = 0; pr_en = 0; wr_en = 0; flush = 0; nx_step = 0;
    @(negedge clk);
    @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule